// File: doc/BRIEF.md
# Periodic Tick Timer

This block generates the periodic interrupt that paces an operating-system scheduler. A reload register holds the period. A control write picks one of three operations: copy the reload value into the counter, let the counter run downward, or freeze it. The same write also selects the count rate, which is either one step per clock or one step every `PRESCALE` clocks. When the counter steps down from zero, it refills from the reload register and raises a pending flag. Software can read the live count at any time. The time elapsed in the current period is then the reload value minus the value read.

The pending flag passes through a mask before it reaches the interrupt output. A status word shows both the raw flag and the masked flag. Writing a one to the acknowledge bit clears the flag. All registers sit behind a plain write port and a combinational read port, each with a two-bit address.

Top module: `tick_timer`

## Requirements
- R1: Control bit 2 selects the count rate. With bit 2 at 0 the counter steps on every running clock. With bit 2 at 1 it steps once every `PRESCALE` running clocks. The prescale phase restarts on every control write, and no step happens in the cycle of a control write.
- R2: A control write (address 1) with bits [1:0] = 01 copies the reload register into the counter and stops counting.
- R3: A control write with bits [1:0] = 10 starts the counter stepping down by one from its present value, without reloading.
- R4: Reads at address 0 return the reload register. Reads at address 1 return the live counter.
- R5: A step taken when the counter is 0 loads the counter from the reload register and sets the raw pending flag. The period is therefore reload+1 steps.
- R6: The mask is bit 0 at address 2 (read and write). Reads at address 3 return the raw flag in bit 1 and raw AND mask in bit 0. `irq` equals that masked bit.
- R7: A write to address 3 with data bit 0 = 1 clears the raw flag. With bit 0 = 0 the write has no effect.
- R8: Rewriting the reload register while running leaves the counter untouched. The new value is used from the next reload on.
- R9: A control write with bits [1:0] = 00 or 11 freezes the counter at its current value.
- R10: If a reload and an acknowledge fall in the same cycle, the raw flag stays set.
- R11: After reset the counter and reload register are 0, the counter is stopped at the full rate, the mask is 0 and no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 control, 2 mask, 3 acknowledge |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address: 0 reload, 1 counter, 2 mask, 3 status |
| rd_data | output | CNT_W | Read data, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach is an acknowledge that lands in exactly the cycle the counter steps from zero. Hitting it requires knowing the phase of both the count and the prescaler. The directed part of the stimulus loads a small reload value, starts the counter, and counts cycles so that the acknowledge write coincides with the reload. Random traffic then mixes divider rewrites, rate changes, holds and acknowledges against a cycle model, which produces further collisions by chance.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [1:0] A_DIV = 2'd0, A_CTRL = 2'd1, A_MASK = 2'd2, A_ACK = 2'd3;
  localparam logic [1:0] OP_LOAD = 2'b01, OP_RUN = 2'b10;

  logic [CNT_W-1:0] div_q, cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             run_q, slow_q, mask_q, raw_q;

  logic ctrl_wr, ack, tick, underflow;
  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign ack       = wr_en && (wr_addr == A_ACK) && wr_data[0];
  assign tick      = run_q && !ctrl_wr && (!slow_q || (pre_q == PRE_LAST));
  assign underflow = tick && (cnt_q == '0);
  assign irq       = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
      slow_q <= 1'b0;
      mask_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_DIV)  div_q  <= wr_data;
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[0];

      if (ctrl_wr) begin
        slow_q <= wr_data[2];
        run_q  <= (wr_data[1:0] == OP_RUN);
        if (wr_data[1:0] == OP_LOAD) cnt_q <= div_q;
      end else if (underflow) begin
        cnt_q <= div_q;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (ctrl_wr || !run_q || !slow_q || pre_q == PRE_LAST) pre_q <= '0;
      else                                                   pre_q <= pre_q + 1'b1;

      if (underflow)  raw_q <= 1'b1;
      else if (ack)   raw_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DIV:   rd_data = div_q;
      A_CTRL:  rd_data = cnt_q;
      A_MASK:  rd_data = {{(CNT_W-1){1'b0}}, mask_q};
      default: rd_data = {{(CNT_W-2){1'b0}}, raw_q, irq};
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic [1:0]       wr_op,
  input logic             ack,
  input logic             tick,
  input logic             underflow,
  input logic             run_q,
  input logic             mask_q,
  input logic             raw_q,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] div_q
);
  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_op == 2'b01) |=> (cnt_q == $past(div_q) && !run_q));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r5_reload_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && cnt_q == '0) |=> (raw_q && cnt_q == $past(div_q)));

  a_r6_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |-> !irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !underflow) |=> !raw_q);

  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctrl_wr) |=> $stable(cnt_q));

  a_r10_reload_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ack) |=> raw_q);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_op(wr_data[1:0]),
  .ack(ack), .tick(tick), .underflow(underflow), .run_q(run_q),
  .mask_q(mask_q), .raw_q(raw_q), .irq(irq), .cnt_q(cnt_q), .div_q(div_q)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam int W  = 32;
  localparam int PS = 4;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq;

  tick_timer #(.CNT_W(W), .PRESCALE(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [W-1:0] m_div, m_cnt;
  int  m_pre;
  bit  m_run, m_slow, m_mask, m_raw;

  function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_div;
      2'd1: return m_cnt;
      2'd2: return {{(W-1){1'b0}}, m_mask};
      default: return {{(W-2){1'b0}}, m_raw, m_raw & m_mask};
    endcase
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] wa, input logic [W-1:0] wd,
                      input logic [1:0] ra, input string tag);
    bit cw, tk, uf, ak;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    cw = we && wa == 2'd1;
    ak = we && wa == 2'd3 && wd[0];
    tk = m_run && !cw && (!m_slow || m_pre == PS - 1);
    uf = tk && m_cnt == '0;
    @(posedge clk);
    #1;
    if (cw || !m_run || !m_slow || m_pre == PS - 1) m_pre = 0; else m_pre++;
    if (cw) begin
      m_slow = wd[2];
      m_run  = (wd[1:0] == 2'b10);
      if (wd[1:0] == 2'b01) m_cnt = m_div;
    end else if (uf) m_cnt = m_div;
    else if (tk) m_cnt = m_cnt - 1;
    if (uf) m_raw = 1; else if (ak) m_raw = 0;
    if (we && wa == 2'd0) m_div = wd;
    if (we && wa == 2'd2) m_mask = wd[0];
    wr_en = 1'b0;
    #1;
    check(rd_data, exp_rd(ra), tag);
    check({{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_raw & m_mask}, {tag, " irq"});
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [1:0] ra, input string tag);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, ra, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_div = '0; m_cnt = '0; m_pre = 0; m_run = 0; m_slow = 0; m_mask = 0; m_raw = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      check(rd_data, '0, "R11 reset state");
    end
    check({{(W-1){1'b0}}, irq}, '0, "R11 reset irq");
    idle(2, 2'd1, "R11 stopped after reset");

    step(1, 2'd0, 32'd5, 2'd0, "R4 reload readback");
    step(1, 2'd1, 32'h1, 2'd1, "R2 load copies");
    idle(3, 2'd1, "R2 load does not count");
    step(1, 2'd1, 32'h2, 2'd1, "R3 run starts");
    check(rd_data, 32'd5, "R3 no reload at start");
    idle(5, 2'd1, "R3 step down");
    check(rd_data, 32'd0, "R3 reaches zero");
    step(0, 2'd0, '0, 2'd3, "R5 reload sets flag");
    check(rd_data, 32'h2, "R5 raw set, masked clear");
    rd_addr = 2'd1; #1;
    check(rd_data, 32'd5, "R5 reload value");
    step(1, 2'd2, 32'h1, 2'd3, "R6 mask on");
    check({{(W-1){1'b0}}, irq}, 32'd1, "R6 irq follows mask");
    step(1, 2'd3, 32'h0, 2'd3, "R7 ack bit0=0 ignored");
    step(1, 2'd3, 32'h1, 2'd3, "R7 ack clears");
    check(rd_data, 32'h0, "R7 status cleared");

    step(1, 2'd0, 32'd9, 2'd1, "R8 rewrite while running");
    idle(12, 2'd1, "R8 new value at next reload");
    step(1, 2'd1, 32'h0, 2'd1, "R9 hold");
    idle(4, 2'd1, "R9 frozen");

    step(1, 2'd0, 32'd2, 2'd1, "R10 setup");
    step(1, 2'd1, 32'h1, 2'd1, "R10 load");
    step(1, 2'd1, 32'h2, 2'd1, "R10 run");
    idle(2, 2'd1, "R10 count");
    check(rd_data, 32'd0, "R10 at zero");
    step(1, 2'd3, 32'h1, 2'd3, "R10 reload beats ack");
    check(rd_data, 32'h3, "R10 still pending");

    step(1, 2'd1, 32'h6, 2'd1, "R1 slow rate");
    idle(3 * PS, 2'd1, "R1 one step per prescale");

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] ra = 2'($urandom_range(0, 3));
      if (r < 8)       step(1, 2'd0, W'($urandom_range(0, 12)), ra, "R8 random reload");
      else if (r < 14) step(1, 2'd1, W'($urandom_range(0, 7)), ra, "R1 random control");
      else if (r < 18) step(1, 2'd2, W'($urandom_range(0, 1)), ra, "R6 random mask");
      else if (r < 26) step(1, 2'd3, W'($urandom_range(0, 1)), ra, "R7 random ack");
      else             step(0, 2'd0, '0, ra, "R5 random run");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule